// File: doc/BRIEF.md
# Multi-Plane Flash Page Read Streamer

This block moves page data from the cache buffers of up to four flash planes to a byte-wide output during a read. The host gives a starting column, a mask of the planes that take part and a timing mode, then pulls bytes with an active-low read strobe. Inside, whole four-byte words travel from the buffers through three register stages. A small word queue at the end is read out one byte at a time through a byte selector placed at the output. Because each fetch brings in four bytes, the internal path can run at a quarter of the byte rate and still feed an uninterrupted double-data-rate stream.

The cache buffers are synthesizable register arrays, one per plane. They are filled through a simple word write port that stands in for the sensing path. A read walks the columns of the first enabled plane from the start column up to the end of its page. It then moves on to column 0 of the next enabled plane, skipping planes whose mask bit is clear. When every enabled plane has been read, the block returns filler bytes and raises an end-of-data flag.

Top module: `flash_rd_pipe`

## Requirements
- R1: After reset, `dvalid`, `eod` and `dqs` are 0, and read strobes given before any read start produce no valid byte.
- R2: When `rd_start` is sampled high at clock edge k, `dvalid` is 0 after edges k, k+1 and k+2, and 1 after edge k+3.
- R3: Column c of plane p is byte bits [8*(c mod 4)+7 : 8*(c mod 4)] of buffer word c/4 of that plane. The first byte shown is at `start_col`, which may be any byte column, including one that is not aligned to a word.
- R4: With `ddr_mode`=0, one byte is consumed at each clock edge where `re_n` is 0 and was 1 at the previous edge. Holding `re_n` low consumes no further bytes.
- R5: With `ddr_mode`=1, every clock edge with `re_n` low and `dvalid` high consumes one byte and toggles `dqs`. `rd_start` clears `dqs` to 0, and `dqs` stays unchanged while `ddr_mode`=0.
- R6: Once `dvalid` has risen, holding `re_n` low in DDR mode gives consecutive bytes on every clock with `dvalid` staying 1.
- R7: After the last column (PAGE_BYTES-1) of a plane, output continues at column 0 of the lowest-numbered plane above it whose mask bit is set.
- R8: Past the last column of the last enabled plane, or at once when the mask is all zero, every byte is 0xFF with `eod`=1. Before that point `eod` is 0.
- R9: A `rd_start` in the middle of a read discards every byte in flight and restarts from the new column and mask with the latency of R2.
- R10: A write with `ld_en`=1 stores `ld_data` into word `ld_waddr` of plane `ld_plane`, and later reads return the new contents.
- R11: Read strobes given while `dvalid` is 0 are ignored, so the first byte after the pipeline fills is still the one at `start_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one output byte at most per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Cache buffer word write enable |
| ld_plane | input | PL_W | Plane selected for the write |
| ld_waddr | input | WA_W | Word address within the page for the write |
| ld_data | input | 32 | Four bytes to store, lowest column in bits 7:0 |
| rd_start | input | 1 | Starts a new read and flushes the pipeline |
| start_col | input | COL_W | Byte column where the read begins |
| plane_mask | input | NUM_PLANES | Planes that take part in the read, captured at start |
| ddr_mode | input | 1 | 1: byte per clock while strobe low; 0: byte per strobe fall |
| re_n | input | 1 | Active-low read strobe |
| dout | output | 8 | Current output byte |
| dvalid | output | 1 | `dout` holds a valid byte |
| eod | output | 1 | The current byte lies past the last enabled plane |
| dqs | output | 1 | Data strobe, toggled per byte in DDR mode |

## Verification
The assertions assume that `plane_mask` fits within eight planes, that `ddr_mode` is held constant from a read start until the next one, and that no buffer word is rewritten while a read of that plane is in flight. The stimulus changes `ddr_mode` and the mask only in the cycle that raises `rd_start`. It fills all buffers before the first read and rewrites a word only between reads. The checks on the strobe toggle and the end-of-data filler rely on `rd_start` being a single-cycle pulse, which the stimulus always drives.

// File: rtl/frp_pkg.sv
package frp_pkg;

  localparam int FRP_MAX_PLANES = 8;

  typedef struct packed {
    logic       found;
    logic [2:0] idx;
  } plane_pick_t;

  // Lowest set mask bit at or above position 'from'.
  function automatic plane_pick_t frp_next_plane(input logic [FRP_MAX_PLANES-1:0] mask,
                                                 input logic [3:0] from);
    plane_pick_t res;
    res = '0;
    for (int i = FRP_MAX_PLANES - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from))) begin
        res.found = 1'b1;
        res.idx   = 3'(i);
      end
    end
    return res;
  endfunction

  // Byte lane selection inside a fetched four-byte word.
  function automatic logic [7:0] frp_pick_byte(input logic [31:0] w, input logic [1:0] sel);
    return w[8*sel +: 8];
  endfunction

  // Byte lane that follows 'sel'; wraps to 0 after lane 3.
  function automatic logic [1:0] frp_next_lane(input logic [1:0] sel);
    return sel + 2'd1;
  endfunction

endpackage

// File: rtl/frp_cache_bank.sv
module frp_cache_bank #(
  parameter int WORDS = 16,
  parameter int WA_W  = 4
) (
  input  logic            clk,
  input  logic            we,
  input  logic [WA_W-1:0] waddr,
  input  logic [31:0]     wdata,
  input  logic [WA_W-1:0] raddr,
  output logic [31:0]     rdata
);

  logic [31:0] mem [WORDS];

  // Registered read: this register forms the second pipeline stage.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/frp_fetch_ctrl.sv
module frp_fetch_ctrl
  import frp_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  parameter int PAGE_BYTES = 64,
  parameter int COL_W      = 6,
  parameter int WA_W       = 4,
  parameter int PL_W       = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [NUM_PLANES-1:0] plane_mask,
  input  logic                  credit_ok,
  output logic                  s1_v,
  output logic [PL_W-1:0]       s1_plane,
  output logic [WA_W-1:0]       s1_waddr,
  output logic                  s1_eod
);

  localparam logic [WA_W-1:0] LAST_WORD = WA_W'(PAGE_BYTES / 4 - 1);

  logic                  active;
  logic                  done;
  logic [PL_W-1:0]       cur_plane;
  logic [WA_W-1:0]       cur_waddr;
  logic [NUM_PLANES-1:0] mask_q;
  plane_pick_t           pick_first;
  plane_pick_t           pick_next;
  logic                  issue;
  logic                  at_page_end;

  assign pick_first  = frp_next_plane(FRP_MAX_PLANES'(plane_mask), 4'd0);
  assign pick_next   = frp_next_plane(FRP_MAX_PLANES'(mask_q), 4'(cur_plane) + 4'd1);
  assign issue       = active && credit_ok;
  assign at_page_end = (cur_waddr == LAST_WORD);

  // Stage 1: word address counter and issue register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      done      <= 1'b0;
      cur_plane <= '0;
      cur_waddr <= '0;
      mask_q    <= '0;
      s1_v      <= 1'b0;
      s1_plane  <= '0;
      s1_waddr  <= '0;
      s1_eod    <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      mask_q    <= plane_mask;
      s1_v      <= 1'b0;
      done      <= !pick_first.found;
      cur_plane <= PL_W'(pick_first.idx);
      cur_waddr <= start_col[COL_W-1:2];
    end else begin
      s1_v <= issue;
      if (issue) begin
        s1_plane <= cur_plane;
        s1_waddr <= cur_waddr;
        s1_eod   <= done;
        if (!done) begin
          if (at_page_end) begin
            if (pick_next.found) begin
              cur_plane <= PL_W'(pick_next.idx);
              cur_waddr <= '0;
            end else begin
              done <= 1'b1;
            end
          end else begin
            cur_waddr <= cur_waddr + 1'b1;
          end
        end
      end
    end
  end

  // R7
  plane_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_eod) |-> mask_q[s1_plane]);

  // R9
  start_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !s1_v);

endmodule

// File: rtl/frp_word_fifo.sv
module frp_word_fifo
  import frp_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       clr_lane,
  input  logic             push,
  input  logic [31:0]      push_word,
  input  logic             push_eod,
  input  logic             pop_byte,
  output logic [7:0]       head_byte,
  output logic             head_eod,
  output logic             not_empty,
  output logic [CNT_W-1:0] count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0]      words [DEPTH];
  logic             eods  [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic [1:0]       lane;
  logic             word_pop;

  assign not_empty = (count != '0);
  assign word_pop  = pop_byte && (lane == 2'd3);
  assign head_byte = frp_pick_byte(words[rptr], lane);
  assign head_eod  = eods[rptr];

  always_ff @(posedge clk) begin
    if (push && !clr) begin
      words[wptr] <= push_word;
      eods[wptr]  <= push_eod;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      lane  <= 2'd0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      lane  <= clr_lane;
    end else begin
      if (push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (word_pop) rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (pop_byte) lane <= frp_next_lane(lane);
      count <= count + CNT_W'(push) - CNT_W'(word_pop);
    end
  end

  // R6
  fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> ((count < CNT_W'(DEPTH)) || word_pop));

  // R11
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_byte |-> not_empty);

endmodule

// File: rtl/flash_rd_pipe.sv
module flash_rd_pipe
  import frp_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  parameter int PAGE_BYTES = 64,
  parameter int DEPTH      = 4,
  localparam int COL_W     = $clog2(PAGE_BYTES),
  localparam int WA_W      = COL_W - 2,
  localparam int PL_W      = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_en,
  input  logic [PL_W-1:0]       ld_plane,
  input  logic [WA_W-1:0]       ld_waddr,
  input  logic [31:0]           ld_data,
  input  logic                  rd_start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [NUM_PLANES-1:0] plane_mask,
  input  logic                  ddr_mode,
  input  logic                  re_n,
  output logic [7:0]            dout,
  output logic                  dvalid,
  output logic                  eod,
  output logic                  dqs
);

  localparam int WORDS   = PAGE_BYTES / 4;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int FLIGHT_W = CNT_W + 1;

  // Stage 1 (strobe register and column counter)
  logic                  re_n_q;
  logic                  s1_v;
  logic [PL_W-1:0]       s1_plane;
  logic [WA_W-1:0]       s1_waddr;
  logic                  s1_eod;
  // Stage 2 (decode, cache select, second sense)
  logic                  s2_v;
  logic [PL_W-1:0]       s2_plane;
  logic                  s2_eod;
  logic [31:0]           bank_q [NUM_PLANES];
  // Stage 3 (plane multiplexing)
  logic [31:0]           s3_word;
  logic                  s3_push;
  // Output side
  logic [CNT_W-1:0]      fifo_cnt;
  logic [FLIGHT_W-1:0]   in_flight;
  logic                  credit_ok;
  logic                  pop_req;
  logic                  pop_evt;
  logic [7:0]            head_byte;
  logic                  head_eod;
  logic                  not_empty;

  assign in_flight = FLIGHT_W'(fifo_cnt) + FLIGHT_W'(s1_v) + FLIGHT_W'(s2_v);
  assign credit_ok = (in_flight < FLIGHT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) re_n_q <= 1'b1;
    else        re_n_q <= re_n;
  end

  assign pop_req = ddr_mode ? !re_n : (re_n_q && !re_n);
  assign pop_evt = pop_req && not_empty && !rd_start;

  frp_fetch_ctrl #(
    .NUM_PLANES (NUM_PLANES),
    .PAGE_BYTES (PAGE_BYTES),
    .COL_W      (COL_W),
    .WA_W       (WA_W),
    .PL_W       (PL_W)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rd_start),
    .start_col  (start_col),
    .plane_mask (plane_mask),
    .credit_ok  (credit_ok),
    .s1_v       (s1_v),
    .s1_plane   (s1_plane),
    .s1_waddr   (s1_waddr),
    .s1_eod     (s1_eod)
  );

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_bank
    frp_cache_bank #(
      .WORDS (WORDS),
      .WA_W  (WA_W)
    ) u_bank (
      .clk   (clk),
      .we    (ld_en && (ld_plane == PL_W'(p))),
      .waddr (ld_waddr),
      .wdata (ld_data),
      .raddr (s1_waddr),
      .rdata (bank_q[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v     <= 1'b0;
      s2_plane <= '0;
      s2_eod   <= 1'b0;
    end else begin
      s2_v     <= s1_v && !rd_start;
      s2_plane <= s1_plane;
      s2_eod   <= s1_eod;
    end
  end

  assign s3_word = s2_eod ? 32'hFFFF_FFFF : bank_q[s2_plane];
  assign s3_push = s2_v;

  frp_word_fifo #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rd_start),
    .clr_lane  (start_col[1:0]),
    .push      (s3_push),
    .push_word (s3_word),
    .push_eod  (s2_eod),
    .pop_byte  (pop_evt),
    .head_byte (head_byte),
    .head_eod  (head_eod),
    .not_empty (not_empty),
    .count     (fifo_cnt)
  );

  assign dout   = head_byte;
  assign dvalid = not_empty;
  assign eod    = not_empty && head_eod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dqs <= 1'b0;
    else if (rd_start)             dqs <= 1'b0;
    else if (pop_evt && ddr_mode)  dqs <= !dqs;
  end

  // R2
  start_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !dvalid);

  // R8
  eod_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eod |-> (dout == 8'hFF));

  // R5
  dqs_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && ddr_mode) |=> (dqs != $past(dqs)));

  // R5
  dqs_async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ddr_mode && !rd_start) |=> $stable(dqs));

endmodule

// File: tb/flash_rd_pipe_bench.sv
module flash_rd_pipe_bench;

  localparam int NP = 4;
  localparam int PB = 64;
  localparam int WPP = PB / 4;

  // Vector fields: [20] ddr, [19:16] mask, [15:10] start column, [9:0] byte count
  localparam logic [20:0] VEC [7] = '{
    {1'b1, 4'hF, 6'd0,  10'd20},
    {1'b0, 4'h1, 6'd5,  10'd8},
    {1'b1, 4'h5, 6'd60, 10'd10},
    {1'b1, 4'h8, 6'd62, 10'd6},
    {1'b0, 4'hA, 6'd63, 10'd4},
    {1'b1, 4'h0, 6'd0,  10'd3},
    {1'b1, 4'hF, 6'd3,  10'd200}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_plane = '0;
  logic [3:0]  ld_waddr = '0;
  logic [31:0] ld_data = '0;
  logic        rd_start = 1'b0;
  logic [5:0]  start_col = '0;
  logic [3:0]  plane_mask = '0;
  logic        ddr_mode = 1'b0;
  logic        re_n = 1'b1;
  logic [7:0]  dout;
  logic        dvalid;
  logic        eod;
  logic        dqs;

  int checks = 0;
  int fails = 0;
  logic [7:0] shadow [NP][PB];

  always #2.5 clk = ~clk;

  flash_rd_pipe u_flash_rd_pipe (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_plane(ld_plane), .ld_waddr(ld_waddr),
    .ld_data(ld_data), .rd_start(rd_start), .start_col(start_col), .plane_mask(plane_mask),
    .ddr_mode(ddr_mode), .re_n(re_n), .dout(dout), .dvalid(dvalid), .eod(eod), .dqs(dqs)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] pat(int p, int c);
    return 8'(p * 37 + c * 11 + 5);
  endfunction

  // Expected {eod, byte} for the k-th byte of a read
  function automatic logic [8:0] exp_at(logic [3:0] m, int s, int k);
    int p = -1;
    int col = s;
    for (int i = 0; i < NP; i++) if (m[i] && p < 0) p = i;
    if (p < 0) return {1'b1, 8'hFF};
    for (int j = 0; j < k; j++) begin
      col++;
      if (col == PB) begin
        int np = -1;
        for (int i = p + 1; i < NP; i++) if (m[i] && np < 0) np = i;
        if (np < 0) return {1'b1, 8'hFF};
        p = np;
        col = 0;
      end
    end
    return {1'b0, shadow[p][col]};
  endfunction

  task automatic load_word(int p, int w);
    @(negedge clk);
    ld_en = 1'b1;
    ld_plane = 2'(p);
    ld_waddr = 4'(w);
    ld_data = {shadow[p][4*w+3], shadow[p][4*w+2], shadow[p][4*w+1], shadow[p][4*w]};
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_read(input bit ddr, input logic [3:0] m, input int s, input int n,
                          input bit early, input string pre);
    logic [8:0] e;
    @(negedge clk);
    re_n = 1'b1;
    ddr_mode = ddr;
    plane_mask = m;
    start_col = 6'(s);
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    chk(dvalid == 1'b0, {pre, " R2 blank after edge k"}, dvalid, 0);
    if (early) re_n = 1'b0;
    @(negedge clk);
    chk(dvalid == 1'b0, {pre, " R2 blank after edge k+1"}, dvalid, 0);
    re_n = 1'b1;
    @(negedge clk);
    chk(dvalid == 1'b0, {pre, " R2 blank after edge k+2"}, dvalid, 0);
    @(negedge clk);
    chk(dvalid == 1'b1, {pre, " R2 valid after edge k+3"}, dvalid, 1);
    for (int k = 0; k < n; k++) begin
      e = exp_at(m, s, k);
      chk(dvalid == 1'b1, {pre, " R6 valid held"}, dvalid, 1);
      chk(dout == e[7:0], early && k == 0 ? {pre, " R11 first byte"} : {pre, " R3 R7 byte"},
          dout, e[7:0]);
      chk(eod == e[8], {pre, " R8 eod flag"}, eod, e[8]);
      chk(dqs == (ddr ? 1'(k % 2) : 1'b0), {pre, " R5 dqs"}, dqs, ddr ? k % 2 : 0);
      re_n = 1'b0;
      @(negedge clk);
      if (!ddr) begin
        re_n = 1'b1;
        @(negedge clk);
      end
    end
    re_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [8:0] e;
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < PB; c++) shadow[p][c] = pat(p, c);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dvalid == 1'b0, "R1 dvalid in reset", dvalid, 0);
    chk(eod == 1'b0, "R1 eod in reset", eod, 0);
    chk(dqs == 1'b0, "R1 dqs in reset", dqs, 0);
    rst_n = 1'b1;
    @(negedge clk);
    re_n = 1'b0;
    @(negedge clk);
    re_n = 1'b1;
    @(negedge clk);
    chk(dvalid == 1'b0, "R1 strobe before start", dvalid, 0);

    for (int p = 0; p < NP; p++)
      for (int w = 0; w < WPP; w++) load_word(p, w);

    for (int v = 0; v < 7; v++) begin
      logic [20:0] ent;
      ent = VEC[v];
      run_read(ent[20], ent[19:16], int'(ent[15:10]), int'(ent[9:0]), 1'b0, "vec");
    end

    // R11 strobe during fill is ignored
    run_read(1'b0, 4'h4, 9, 3, 1'b1, "early");

    // R4 holding the strobe low consumes a single byte
    run_read(1'b0, 4'h1, 0, 2, 1'b0, "R4");
    @(negedge clk);
    re_n = 1'b0;
    repeat (3) @(negedge clk);
    e = exp_at(4'h1, 0, 3);
    chk(dout == e[7:0], "R4 held low single byte", dout, e[7:0]);
    chk(dqs == 1'b0, "R5 dqs idle in async", dqs, 0);
    re_n = 1'b1;
    @(negedge clk);
    re_n = 1'b0;
    @(negedge clk);
    re_n = 1'b1;
    @(negedge clk);
    e = exp_at(4'h1, 0, 4);
    chk(dout == e[7:0], "R4 next fall advances", dout, e[7:0]);

    // R9 restart in the middle of a stream
    run_read(1'b1, 4'hF, 10, 5, 1'b0, "R9 first");
    run_read(1'b1, 4'h2, 40, 30, 1'b0, "R9 restarted");

    // R10 rewrite one buffer word between reads
    shadow[1][12] = 8'hEF;
    shadow[1][13] = 8'hBE;
    shadow[1][14] = 8'hAD;
    shadow[1][15] = 8'hDE;
    load_word(1, 3);
    run_read(1'b0, 4'h2, 12, 4, 1'b0, "R10");
    chk(shadow[1][13] == 8'hBE, "R10 model word", shadow[1][13], 8'hBE);

    finish_run();
  end

endmodule